// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous memory, with registers on its inputs and on its read data path. It holds a small parameterised array. By default that array is 256 words of 36 bits, split into four 9-bit byte lanes.

An access begins on a rising clock edge when one of two active-low address strobes is low and the chip is selected. The chip is selected only when three chip enables agree. The strobe loads the start address. Later cycles without a strobe continue the access. In each such cycle an advance input may step a 2-bit beat counter, and the low two address bits then follow a linear or an interleaved order. Upper address bits never change during a burst.

Writes use per-byte lane enables, qualified by a byte-write enable, or a global write that covers every lane. Read data reaches the pins one edge after the cycle in which the array is addressed. When the chip is deselected, an extra pipelined drive register keeps the data pins driven for one more cycle. An asynchronous output enable gates the pad drive at any moment.

The control is a three-state machine:
- `ST_DESEL`: no access in flight.
- `ST_READ`: a read addresses the array in this cycle.
- `ST_WRITE`: a write is committed at the end of this cycle.

The machine has four named transitions:
- **START_READ**: a strobe while selected leads to `ST_READ`. This happens for the processor strobe in every case, and for the controller strobe when no write is requested.
- **START_WRITE**: the controller strobe while selected, with a write requested, leads to `ST_WRITE`.
- **CONTINUE**: no strobe, while in `ST_READ` or `ST_WRITE`, leads to `ST_WRITE` if a write is requested and to `ST_READ` otherwise.
- **DESELECT**: a strobe while not selected leads to `ST_DESEL`.

Top module: `burst_sram_pipe`

## Requirements
- R1: After reset, `dq_oe` is 0 and the block is deselected until a strobe arrives with the chip selected.
- R2: The chip is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A strobe while not selected starts no access, writes nothing and takes the block to the deselected state.
- R3: A selected edge with `strobe_cpu_n`=0 starts a read even when write controls are active. No array word changes.
- R4: For a read started at edge k, the addressed word is on `dq_out`, with `dq_oe`=1, after edge k+1. Each further burst beat takes one more cycle.
- R5: With `seq_lin`=1, beat n addresses the start address with its low two bits replaced by (start low bits + n) mod 4. After the fourth beat, the burst wraps to the starting word of the same 4-word group.
- R6: With `seq_lin`=0, beat n uses the low bits start XOR n. The mode is taken at the edge that starts the access.
- R7: A write with `byte_wr_en_n`=0 changes only those lanes i (bits 9i+8..9i) whose `byte_we_n[i]`=0. The other lanes keep their contents.
- R8: With `wr_all_n`=0, a write changes all four lanes, whatever `byte_we_n` and `byte_wr_en_n` are.
- R9: The controller strobe with no write requested is a read. A continuation cycle with no strobe is a write if one is requested and a read otherwise. It uses the current burst address. `adv_n`=0 steps the beat counter, and `adv_n`=1 repeats the same address.
- R10: After the last read cycle before a deselect, `dq_oe` stays 1 for one extra cycle and `dq_out` holds the last word. `dq_oe` is 0 after that.
- R11: `out_en_n`=1 forces `dq_oe` to 0 at once, with no clock edge needed. Returning `out_en_n` to 0 restores the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Start address, loaded by a strobe |
| wdata | input | NUM_BYTES*BYTE_W | Write data |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, always a read |
| strobe_ctl_n | input | 1 | Controller address strobe |
| adv_n | input | 1 | Step the burst counter, active low |
| byte_we_n | input | NUM_BYTES | Per-lane write select, active low |
| byte_wr_en_n | input | 1 | Qualifies the lane selects, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| seq_lin | input | 1 | 1 selects linear order, 0 selects interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | NUM_BYTES*BYTE_W | Read data register |
| dq_oe | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The bound checker checks, on every cycle, that the state machine reacts correctly to each strobe: the processor strobe always leads to a read, and an unselected strobe always leads to a deselect. It also checks that the pad drive follows the read history of the previous two cycles, which covers both the extended deselect cycle and the asynchronous output gate. The bench scenarios are the only place where data correctness is shown. They compare the read data against a reference memory for both burst orders from every start offset, including the wrap to the start word, for masked and global writes, for write bursts, and for unselected writes that must leave the array unchanged.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;

    // low two address bits for a given beat of a 4-word burst
    function automatic logic [1:0] burst_offset(
        input logic [1:0] start,
        input logic [1:0] beat,
        input logic       linear
    );
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_linear,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        beat_q;
    logic              linear_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            beat_q   <= '0;
            linear_q <= 1'b1;
        end else if (load) begin
            base_q   <= load_addr;
            beat_q   <= '0;
            linear_q <= load_linear;
        end else if (step) begin
            beat_q <= beat_q + 2'd1;
        end
    end

    assign cur_addr = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], beat_q, linear_q)};

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int BYTE_W    = 9
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_BYTES-1:0]          wr_lane,
    input  logic [NUM_BYTES*BYTE_W-1:0]   wr_data,
    output logic [NUM_BYTES*BYTE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) begin
                lane_mem[addr] <= wr_data[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[g*BYTE_W +: BYTE_W] = lane_mem[addr];
    end

endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic [DATA_W-1:0] data_q;
    logic              live_q;
    logic              extend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            live_q   <= 1'b0;
            extend_q <= 1'b0;
        end else begin
            live_q   <= capture;
            extend_q <= live_q;
            if (capture) begin
                data_q <= cap_data;
            end
        end
    end

    assign dq_out = data_q;
    assign dq_oe  = !out_en_n && (live_q || extend_q);

endmodule

// File: rtl/burst_sram_pipe.sv
module burst_sram_pipe
    import bsram_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int BYTE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
    input  logic                        cs1_n,
    input  logic                        cs2,
    input  logic                        cs3_n,
    input  logic                        strobe_cpu_n,
    input  logic                        strobe_ctl_n,
    input  logic                        adv_n,
    input  logic [NUM_BYTES-1:0]        byte_we_n,
    input  logic                        byte_wr_en_n,
    input  logic                        wr_all_n,
    input  logic                        seq_lin,
    input  logic                        out_en_n,
    output logic [NUM_BYTES*BYTE_W-1:0] dq_out,
    output logic                        dq_oe
);

    localparam int DATA_W = NUM_BYTES * BYTE_W;

    acc_state_e state_q, state_d;

    logic                 selected;
    logic                 any_strobe;
    logic                 wr_req;
    logic [NUM_BYTES-1:0] lane_req;
    logic                 ctr_load;
    logic                 ctr_step;
    logic [ADDR_W-1:0]    cur_addr;
    logic [DATA_W-1:0]    wdata_q;
    logic [NUM_BYTES-1:0] lanes_q;
    logic [DATA_W-1:0]    array_rd;
    logic                 arr_wr_en;
    logic                 out_capture;

    assign selected   = !cs1_n && cs2 && !cs3_n;
    assign any_strobe = !strobe_cpu_n || !strobe_ctl_n;
    assign lane_req   = !wr_all_n     ? {NUM_BYTES{1'b1}} :
                        !byte_wr_en_n ? ~byte_we_n : {NUM_BYTES{1'b0}};
    assign wr_req     = |lane_req;

    // next state: START_READ, START_WRITE, CONTINUE, DESELECT
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        unique case (state_q)
            ST_DESEL: begin
                if (any_strobe && selected) begin
                    ctr_load = 1'b1;
                    state_d  = (!strobe_cpu_n || !wr_req) ? ST_READ : ST_WRITE;
                end
            end
            ST_READ, ST_WRITE: begin
                if (any_strobe) begin
                    if (selected) begin
                        ctr_load = 1'b1;
                        state_d  = (!strobe_cpu_n || !wr_req) ? ST_READ : ST_WRITE;
                    end else begin
                        state_d = ST_DESEL;
                    end
                end else begin
                    ctr_step = !adv_n;
                    state_d  = wr_req ? ST_WRITE : ST_READ;
                end
            end
            default: state_d = ST_DESEL;
        endcase
    end

    // state register and registered write operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            wdata_q <= '0;
            lanes_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_WRITE) begin
                wdata_q <= wdata;
                lanes_q <= lane_req;
            end
        end
    end

    // outputs of the state machine
    always_comb begin
        arr_wr_en   = 1'b0;
        out_capture = 1'b0;
        unique case (state_q)
            ST_READ:  out_capture = 1'b1;
            ST_WRITE: arr_wr_en   = 1'b1;
            default: ;
        endcase
    end

    bsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ctr_load),
        .step        (ctr_step),
        .load_addr   (addr),
        .load_linear (seq_lin),
        .cur_addr    (cur_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_array (
        .clk     (clk),
        .wr_en   (arr_wr_en),
        .addr    (cur_addr),
        .wr_lane (lanes_q),
        .wr_data (wdata_q),
        .rd_data (array_rd)
    );

    bsram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (out_capture),
        .cap_data (array_rd),
        .out_en_n (out_en_n),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/bsram_checker.sv
module bsram_checker
    import bsram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs1_n,
    input logic       cs2,
    input logic       cs3_n,
    input logic       strobe_cpu_n,
    input logic       strobe_ctl_n,
    input logic       out_en_n,
    input logic       dq_oe,
    input acc_state_e st
);

    logic sel;
    assign sel = !cs1_n && cs2 && !cs3_n;

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_oe);

    assert_cpu_strobe_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && sel) |=> (st == ST_READ));

    assert_unsel_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strobe_cpu_n || !strobe_ctl_n) && !sel) |=> (st == ST_DESEL));

    assert_read_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st) == ST_READ) && !out_en_n) |-> dq_oe);

    assert_extend_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st, 2) == ST_READ) && !out_en_n) |-> dq_oe);

    assert_drive_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st) != ST_READ) && ($past(st, 2) != ST_READ)) |-> !dq_oe);

endmodule

bind burst_sram_pipe bsram_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs1_n        (cs1_n),
    .cs2          (cs2),
    .cs3_n        (cs3_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .out_en_n     (out_en_n),
    .dq_oe        (dq_oe),
    .st           (state_q)
);

// File: tb/test_burst_sram_pipe.sv
module test_burst_sram_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int NUM_BYTES  = 4;
    localparam int BYTE_W     = 9;
    localparam int DATA_W     = NUM_BYTES * BYTE_W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [DATA_W-1:0]    wdata = '0;
    logic                 cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic                 strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
    logic [NUM_BYTES-1:0] byte_we_n = '1;
    logic                 byte_wr_en_n = 1'b1, wr_all_n = 1'b1;
    logic                 seq_lin = 1'b1, out_en_n = 1'b0;
    logic [DATA_W-1:0]    dq_out;
    logic                 dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] ref_mem [1 << ADDR_W];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram_pipe #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) i_burst_sram_pipe (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
        .byte_we_n(byte_we_n), .byte_wr_en_n(byte_wr_en_n), .wr_all_n(wr_all_n),
        .seq_lin(seq_lin), .out_en_n(out_en_n), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [DATA_W-1:0] pattern(input logic [7:0] a, input logic [3:0] salt);
        return {salt, a, ~a, a ^ 8'h3C, a + 8'd7};
    endfunction

    function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base, input int n, input logic lin);
        logic [1:0] b;
        b = 2'(n);
        return {base[ADDR_W-1:2], lin ? base[1:0] + b : base[1:0] ^ b};
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
        byte_we_n = '1; byte_wr_en_n = 1'b1; wr_all_n = 1'b1;
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
    endtask

    task automatic set_desel();
        set_idle();
        strobe_ctl_n = 1'b0;
        cs1_n = 1'b1;
    endtask

    // single write started by the controller strobe, then deselect
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic gw_n, input logic bwe_n, input logic [NUM_BYTES-1:0] bw_n);
        @(negedge clk);
        set_idle();
        strobe_ctl_n = 1'b0; addr = a; wdata = d;
        wr_all_n = gw_n; byte_wr_en_n = bwe_n; byte_we_n = bw_n;
        @(negedge clk);
        set_desel();
        @(negedge clk);
        set_idle();
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (!gw_n || (!bwe_n && !bw_n[i])) ref_mem[a][i*BYTE_W +: BYTE_W] = d[i*BYTE_W +: BYTE_W];
        end
    endtask

    // read burst of n beats via processor strobe; checks data, extension, release
    task automatic read_burst(input string req, input logic [ADDR_W-1:0] base, input logic lin, input int n);
        logic [DATA_W-1:0] last;
        @(negedge clk);
        set_idle();
        strobe_cpu_n = 1'b0; addr = base; seq_lin = lin;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                check({req, " beat data"}, dq_out, ref_mem[beat_addr(base, j-2, lin)]);
                check({req, " beat drive R4"}, DATA_W'(dq_oe), DATA_W'(1));
            end
            set_idle();
            if (j < n) adv_n = 1'b0;
            else begin
                set_desel();
            end
        end
        @(negedge clk);
        set_idle();
        last = ref_mem[beat_addr(base, n-1, lin)];
        check({req, " last beat"}, dq_out, last);
        @(negedge clk);
        check("R10 extended drive", DATA_W'(dq_oe), DATA_W'(1));
        check("R10 extended data held", dq_out, last);
        @(negedge clk);
        check("R10 drive released", DATA_W'(dq_oe), DATA_W'(0));
    endtask

    task automatic test_reset();
        check("R1 no drive after reset", DATA_W'(dq_oe), DATA_W'(0));
        @(negedge clk);
        check("R1 still idle", DATA_W'(dq_oe), DATA_W'(0));
    endtask

    task automatic test_fill_and_bursts();
        for (int k = 0; k < 4; k++) do_write(8'h40 + 8'(k), pattern(8'h40 + 8'(k), 4'h1), 1'b0, 1'b1, '1);
        for (int s = 0; s < 4; s++) begin
            read_burst("R5 linear", 8'h40 + 8'(s), 1'b1, 4);
            read_burst("R6 interleaved", 8'h40 + 8'(s), 1'b0, 4);
        end
        read_burst("R5 wrap", 8'h42, 1'b1, 6);
        read_burst("R6 wrap", 8'h43, 1'b0, 5);
    endtask

    task automatic test_byte_writes();
        do_write(8'h10, pattern(8'h10, 4'h2), 1'b0, 1'b1, '1);
        do_write(8'h10, 36'h0_0000_0000, 1'b1, 1'b0, 4'b1010);
        read_burst("R7 lanes 0,2 written", 8'h10, 1'b1, 1);
        do_write(8'h10, 36'hF_FFFF_FFFF, 1'b1, 1'b1, 4'b0000);
        read_burst("R7 unqualified lanes unchanged", 8'h10, 1'b1, 1);
        do_write(8'h10, 36'h5_A5A5_A5A5, 1'b0, 1'b0, 4'b1111);
        read_burst("R8 global write all lanes", 8'h10, 1'b1, 1);
    endtask

    task automatic test_cpu_strobe_read();
        do_write(8'h20, pattern(8'h20, 4'h3), 1'b0, 1'b1, '1);
        @(negedge clk);
        strobe_cpu_n = 1'b0; addr = 8'h20; wr_all_n = 1'b0; wdata = 36'h0_DEAD_BEEF;
        @(negedge clk);
        set_desel();
        @(negedge clk);
        set_idle();
        check("R3 cpu strobe reads", dq_out, ref_mem[8'h20]);
        read_burst("R3 word untouched", 8'h20, 1'b1, 1);
    endtask

    task automatic test_ctl_read_and_hold();
        @(negedge clk);
        set_idle();
        strobe_ctl_n = 1'b0; addr = 8'h41; byte_we_n = '0;
        @(negedge clk);
        set_idle();
        @(negedge clk);
        set_desel();
        check("R9 ctl strobe read", dq_out, ref_mem[8'h41]);
        @(negedge clk);
        set_idle();
        check("R9 hold repeats address", dq_out, ref_mem[8'h41]);
        check("R9 hold drive", DATA_W'(dq_oe), DATA_W'(1));
        @(negedge clk);
        @(negedge clk);
        check("R10 released after hold", DATA_W'(dq_oe), DATA_W'(0));
    endtask

    task automatic test_write_burst();
        logic [DATA_W-1:0] d [4];
        for (int j = 0; j < 4; j++) d[j] = pattern(8'h80 + 8'(j), 4'h6);
        @(negedge clk);
        set_idle();
        strobe_ctl_n = 1'b0; addr = 8'h82; seq_lin = 1'b0; wr_all_n = 1'b0; wdata = d[0];
        for (int j = 1; j < 4; j++) begin
            @(negedge clk);
            set_idle();
            adv_n = 1'b0; wr_all_n = 1'b0; wdata = d[j];
        end
        @(negedge clk);
        set_desel();
        @(negedge clk);
        set_idle();
        for (int j = 0; j < 4; j++) ref_mem[beat_addr(8'h82, j, 1'b0)] = d[j];
        read_burst("R9 write burst readback", 8'h80, 1'b1, 4);
    endtask

    task automatic test_unselected();
        @(negedge clk);
        set_idle();
        cs2 = 1'b0; strobe_cpu_n = 1'b0; addr = 8'h40;
        @(negedge clk);
        set_idle();
        @(negedge clk);
        check("R2 no drive when unselected", DATA_W'(dq_oe), DATA_W'(0));
        @(negedge clk);
        check("R2 no drive later", DATA_W'(dq_oe), DATA_W'(0));
        cs3_n = 1'b1; strobe_ctl_n = 1'b0; addr = 8'h40; wr_all_n = 1'b0; wdata = '0;
        @(negedge clk);
        set_idle();
        read_burst("R2 unselected write ignored", 8'h40, 1'b1, 1);
    endtask

    task automatic test_async_oe();
        @(negedge clk);
        set_idle();
        strobe_cpu_n = 1'b0; addr = 8'h43;
        @(negedge clk);
        set_desel();
        @(negedge clk);
        set_idle();
        check("R11 driven before gate", DATA_W'(dq_oe), DATA_W'(1));
        out_en_n = 1'b1;
        #1;
        check("R11 gate off at once", DATA_W'(dq_oe), DATA_W'(0));
        out_en_n = 1'b0;
        #1;
        check("R11 gate restored", DATA_W'(dq_oe), DATA_W'(1));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_fill_and_bursts();
        test_byte_writes();
        test_cpu_strobe_read();
        test_ctl_read_and_hold();
        test_write_burst();
        test_unselected();
        test_async_oe();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule